// File: doc/BRIEF.md
# Burst-of-Four Dual-Port Synchronous SRAM Model

This block is a synthesizable model of a static memory with two independent ports: a read port and a write port. The two ports share one address bus and run on a pair of complementary clocks, `clk_k` and `clk_kb`. Every access moves four words, one on each rising edge of either clock, so one burst occupies two `clk_k` cycles. The external address picks a group of four consecutive words. An internal beat counter supplies the two low word-address bits, in the order 0, 1, 2, 3.

Write data is split into lanes of `LANE_W` bits, and each lane has its own active-low enable. The enable travels with each beat. Read data appears two cycles after the read is accepted. It is qualified by a valid flag, and an output-enable pin stands in for a tri-state driver. The model does not apply back-pressure, because the timing is fixed. A port is busy during the second cycle of its own burst, and a select on that cycle is simply not taken. A new burst can start every second cycle on each port, and the read output then runs with no gap between bursts.

Top module: `qb4_sram`

## Requirements
- R1: While `rst_n` is low, and after reset until a read is issued, `q_vld` and `q_oe` are 0 and `q` is all zeros.
- R2: A read is accepted on a `clk_k` rise when `rd_sel_n` is 0 and the read port is idle. Word `addr*4+j` (j = 0..3) is then driven on the half-cycles that start at the `clk_k` rise two cycles later, the next `clk_kb` rise, the next `clk_k` rise and the next `clk_kb` rise, in that order.
- R3: A write is accepted on a `clk_k` rise when `wr_sel_n` is 0 and the write port is idle. Beat j is sampled from `d` and goes to word `addr*4+j`. Beats 0 and 2 are sampled on the accepting `clk_k` rise and on the next one. Beats 1 and 3 are sampled on the `clk_kb` rises that follow each of those.
- R4: `bw_n[l]` = 0 writes lane l, which is bits `l*LANE_W+LANE_W-1 : l*LANE_W`; for example, lane 1 is bits 17:9 when LANE_W is 9. It is sampled on the same edge as the beat. A lane whose enable is 1 keeps its stored value.
- R5: On a `clk_k` rise where the write port is idle and `wr_sel_n` is 1, nothing is stored, whatever `addr`, `d` and `bw_n` carry.
- R6: On the `clk_k` rise right after a port accepts a burst, that port ignores its select.
- R7: A read sees every write beat sampled before its accepting `clk_k` rise. It sees no beat sampled on that rise or later. So a read and a write to the same group on the same edge return the old contents.
- R8: `q_vld` is 1 exactly during the four half-cycles of a read burst. `q_oe` equals `q_vld`. When `q_vld` is 0, `q` is zero.
- R9: Reads issued every second cycle give an unbroken output stream. When the read port is deselected, the burst in flight still completes, and the outputs turn off from the next `clk_k` rise after its last beat.
- R10: The write group is fixed at acceptance. `addr` during the busy cycle does not redirect beats 2 and 3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_k | input | 1 | Primary clock; every access starts on its rising edge |
| clk_kb | input | 1 | Complementary clock, exactly inverse to `clk_k` |
| rst_n | input | 1 | Asynchronous active-low reset of the control state |
| addr | input | GROUP_AW | Group address shared by both ports |
| wr_sel_n | input | 1 | Active-low write port select |
| rd_sel_n | input | 1 | Active-low read port select |
| d | input | LANES*LANE_W | Write data, one beat per clock rise |
| bw_n | input | LANES | Active-low lane write enables, one per lane |
| q | output | LANES*LANE_W | Read data, zero when not valid |
| q_oe | output | 1 | Output-drive enable; low means high impedance |
| q_vld | output | 1 | Read data valid flag |

## Verification
The assertions assume that `clk_kb` is the exact inverse of `clk_k`. They also assume that every input is stable around the rising edge of the clock that samples it. Without both conditions, the half-cycle output mux and the forward path of a beat sampled on `clk_kb` have no meaning. The stimulus moves K-edge inputs a quarter period before each `clk_k` rise and moves data and lane enables a quarter period before each `clk_kb` rise. It holds both selects high through reset and writes every group before the first read, so no read returns uninitialised storage.

// File: rtl/qb4_pkg.sv
`timescale 1ns/1ps
package qb4_pkg;
  // a burst is always four words; the group address drops two low bits
  localparam int BEATS   = 4;
  localparam int BEAT_AW = 2;

  // output phase of the read port in the clk_k domain
  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_FIRST  = 2'd1,
    PH_SECOND = 2'd2
  } rd_phase_e;
endpackage

// File: rtl/qb4_wr_path.sv
`timescale 1ns/1ps
module qb4_wr_path
  import qb4_pkg::*;
#(
  parameter int GROUP_AW = 4,
  parameter int LANES    = 2,
  parameter int LANE_W   = 9,
  localparam int DW      = LANES * LANE_W,
  localparam int WAW     = GROUP_AW + BEAT_AW
) (
  input  logic                clk_k,
  input  logic                clk_kb,
  input  logic                rst_n,
  input  logic                wr_sel_n,
  input  logic [GROUP_AW-1:0] addr,
  input  logic [DW-1:0]       d,
  input  logic [LANES-1:0]    bw_n,
  // beat sampled on clk_kb, committed on the following clk_k rise
  output logic                kb_en,
  output logic [WAW-1:0]      kb_idx,
  output logic [DW-1:0]       kb_dat,
  output logic [LANES-1:0]    kb_lanes,
  // beat sampled straight from the pins on this clk_k rise
  output logic                pin_en,
  output logic [WAW-1:0]      pin_idx,
  output logic [DW-1:0]       pin_dat,
  output logic [LANES-1:0]    pin_lanes
);
  logic [DW-1:0]       kb_dat_q;
  logic [LANES-1:0]    kb_lanes_q;
  logic                take;
  logic                busy_q;
  logic                tail_q;
  logic [GROUP_AW-1:0] grp_q;

  // half-cycle capture: the clk_k domain decides whether it is used
  always_ff @(posedge clk_kb or negedge rst_n) begin
    if (!rst_n) begin
      kb_dat_q   <= '0;
      kb_lanes_q <= '0;
    end else begin
      kb_dat_q   <= d;
      kb_lanes_q <= ~bw_n;
    end
  end

  assign take = !wr_sel_n && !busy_q;

  always_ff @(posedge clk_k or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      tail_q <= 1'b0;
      grp_q  <= '0;
    end else begin
      busy_q <= take;
      tail_q <= busy_q;
      if (take) grp_q <= addr;
    end
  end

  // pin beats: beat 0 on the accepting edge, beat 2 on the busy edge
  assign pin_en    = take || busy_q;
  assign pin_idx   = take ? {addr, BEAT_AW'(0)} : {grp_q, BEAT_AW'(2)};
  assign pin_dat   = d;
  assign pin_lanes = ~bw_n;

  // half-cycle beats: beat 1 lands on the busy edge, beat 3 one edge later
  assign kb_en    = busy_q || tail_q;
  assign kb_idx   = busy_q ? {grp_q, BEAT_AW'(1)} : {grp_q, BEAT_AW'(3)};
  assign kb_dat   = kb_dat_q;
  assign kb_lanes = kb_lanes_q;
endmodule

// File: rtl/qb4_array.sv
`timescale 1ns/1ps
module qb4_array
  import qb4_pkg::*;
#(
  parameter int GROUP_AW = 4,
  parameter int LANES    = 2,
  parameter int LANE_W   = 9,
  localparam int DW      = LANES * LANE_W,
  localparam int WAW     = GROUP_AW + BEAT_AW,
  localparam int WORDS   = BEATS << GROUP_AW
) (
  input  logic                        clk_k,
  input  logic                        kb_en,
  input  logic [WAW-1:0]              kb_idx,
  input  logic [DW-1:0]               kb_dat,
  input  logic [LANES-1:0]            kb_lanes,
  input  logic                        pin_en,
  input  logic [WAW-1:0]              pin_idx,
  input  logic [DW-1:0]               pin_dat,
  input  logic [LANES-1:0]            pin_lanes,
  input  logic [GROUP_AW-1:0]         rd_grp,
  output logic [BEATS-1:0][DW-1:0]    snap
);
  logic [DW-1:0] mem [WORDS];

  // two write ports; the write path never aims both at one word
  always_ff @(posedge clk_k) begin
    for (int l = 0; l < LANES; l++) begin
      if (kb_en && kb_lanes[l])
        mem[kb_idx][l*LANE_W +: LANE_W] <= kb_dat[l*LANE_W +: LANE_W];
      if (pin_en && pin_lanes[l])
        mem[pin_idx][l*LANE_W +: LANE_W] <= pin_dat[l*LANE_W +: LANE_W];
    end
  end

  // whole-group view for a read taken on this edge: the half-cycle beat
  // sampled earlier is forwarded, the pin beat of this edge is not
  for (genvar i = 0; i < BEATS; i++) begin : g_slot
    logic [DW-1:0] stored;
    logic          fwd;
    assign stored = mem[{rd_grp, BEAT_AW'(i)}];
    assign fwd    = kb_en && (kb_idx == {rd_grp, BEAT_AW'(i)});
    for (genvar l = 0; l < LANES; l++) begin : g_lane
      assign snap[i][l*LANE_W +: LANE_W] = (fwd && kb_lanes[l])
                                         ? kb_dat[l*LANE_W +: LANE_W]
                                         : stored[l*LANE_W +: LANE_W];
    end
  end
endmodule

// File: rtl/qb4_rd_path.sv
`timescale 1ns/1ps
module qb4_rd_path
  import qb4_pkg::*;
#(
  parameter int DW = 18
) (
  input  logic                     clk_k,
  input  logic                     clk_kb,
  input  logic                     rst_n,
  input  logic                     rd_sel_n,
  input  logic [BEATS-1:0][DW-1:0] snap,
  output logic                     rd_take,
  output logic [DW-1:0]            q,
  output logic                     q_vld
);
  logic                     lat1_q;
  logic                     lat2_q;
  logic [BEATS-1:0][DW-1:0] held_q;
  logic [BEATS-1:0][DW-1:0] out_q;
  rd_phase_e                ph_q;
  logic [DW-1:0]            qk_q;
  logic                     vk_q;
  logic [DW-1:0]            qkb_q;
  logic                     vkb_q;

  // lat1_q doubles as the busy flag of the read port
  assign rd_take = !rd_sel_n && !lat1_q;

  always_ff @(posedge clk_k or negedge rst_n) begin
    if (!rst_n) begin
      lat1_q <= 1'b0;
      lat2_q <= 1'b0;
      held_q <= '0;
      out_q  <= '0;
      ph_q   <= PH_IDLE;
      qk_q   <= '0;
      vk_q   <= 1'b0;
    end else begin
      lat1_q <= rd_take;
      lat2_q <= lat1_q;
      if (rd_take) held_q <= snap;
      if (lat2_q) begin
        out_q <= held_q;
        qk_q  <= held_q[0];
        vk_q  <= 1'b1;
        ph_q  <= PH_FIRST;
      end else if (ph_q == PH_FIRST) begin
        qk_q  <= out_q[2];
        vk_q  <= 1'b1;
        ph_q  <= PH_SECOND;
      end else begin
        qk_q  <= '0;
        vk_q  <= 1'b0;
        ph_q  <= PH_IDLE;
      end
    end
  end

  // odd beats leave on the complementary edge
  always_ff @(posedge clk_kb or negedge rst_n) begin
    if (!rst_n) begin
      qkb_q <= '0;
      vkb_q <= 1'b0;
    end else begin
      unique case (ph_q)
        PH_FIRST:  begin qkb_q <= out_q[1]; vkb_q <= 1'b1; end
        PH_SECOND: begin qkb_q <= out_q[3]; vkb_q <= 1'b1; end
        default:   begin qkb_q <= '0;       vkb_q <= 1'b0; end
      endcase
    end
  end

  // clk_k high: first half-cycle of a K period, driven by the K register
  assign q     = clk_k ? qk_q : qkb_q;
  assign q_vld = clk_k ? vk_q : vkb_q;
endmodule

// File: rtl/qb4_sram.sv
`timescale 1ns/1ps
module qb4_sram
  import qb4_pkg::*;
#(
  parameter int GROUP_AW = 4,
  parameter int LANES    = 2,
  parameter int LANE_W   = 9,
  localparam int DW      = LANES * LANE_W,
  localparam int WAW     = GROUP_AW + BEAT_AW
) (
  input  logic                clk_k,
  input  logic                clk_kb,
  input  logic                rst_n,
  input  logic [GROUP_AW-1:0] addr,
  input  logic                wr_sel_n,
  input  logic                rd_sel_n,
  input  logic [DW-1:0]       d,
  input  logic [LANES-1:0]    bw_n,
  output logic [DW-1:0]       q,
  output logic                q_oe,
  output logic                q_vld
);
  logic                     kb_en;
  logic [WAW-1:0]           kb_idx;
  logic [DW-1:0]            kb_dat;
  logic [LANES-1:0]         kb_lanes;
  logic                     pin_en;
  logic [WAW-1:0]           pin_idx;
  logic [DW-1:0]            pin_dat;
  logic [LANES-1:0]         pin_lanes;
  logic [BEATS-1:0][DW-1:0] snap;
  logic                     rd_take;

  qb4_wr_path #(.GROUP_AW(GROUP_AW), .LANES(LANES), .LANE_W(LANE_W)) u_wr (
    .clk_k(clk_k), .clk_kb(clk_kb), .rst_n(rst_n),
    .wr_sel_n(wr_sel_n), .addr(addr), .d(d), .bw_n(bw_n),
    .kb_en(kb_en), .kb_idx(kb_idx), .kb_dat(kb_dat), .kb_lanes(kb_lanes),
    .pin_en(pin_en), .pin_idx(pin_idx), .pin_dat(pin_dat), .pin_lanes(pin_lanes)
  );

  qb4_array #(.GROUP_AW(GROUP_AW), .LANES(LANES), .LANE_W(LANE_W)) u_mem (
    .clk_k(clk_k),
    .kb_en(kb_en), .kb_idx(kb_idx), .kb_dat(kb_dat), .kb_lanes(kb_lanes),
    .pin_en(pin_en), .pin_idx(pin_idx), .pin_dat(pin_dat), .pin_lanes(pin_lanes),
    .rd_grp(addr), .snap(snap)
  );

  qb4_rd_path #(.DW(DW)) u_rd (
    .clk_k(clk_k), .clk_kb(clk_kb), .rst_n(rst_n),
    .rd_sel_n(rd_sel_n), .snap(snap), .rd_take(rd_take),
    .q(q), .q_vld(q_vld)
  );

  // the drive enable follows the valid flag
  assign q_oe = q_vld;
endmodule

// File: rtl/qb4_sram_chk.sv
`timescale 1ns/1ps
module qb4_sram_chk #(
  parameter int DW  = 18,
  parameter int WAW = 6
) (
  input logic           clk_k,
  input logic           clk_kb,
  input logic           rst_n,
  input logic           rd_sel_n,
  input logic           wr_sel_n,
  input logic [DW-1:0]  q,
  input logic           q_vld,
  input logic           kb_en,
  input logic [WAW-1:0] kb_idx,
  input logic           pin_en,
  input logic [WAW-1:0] pin_idx
);
  logic rbusy_q;
  logic wbusy_q;
  logic rd_go;

  // the checker keeps its own view of port occupancy
  assign rd_go = !rd_sel_n && !rbusy_q;

  always_ff @(posedge clk_k or negedge rst_n) begin
    if (!rst_n) begin
      rbusy_q <= 1'b0;
      wbusy_q <= 1'b0;
    end else begin
      rbusy_q <= rd_go;
      wbusy_q <= !wr_sel_n && !wbusy_q;
    end
  end

  // R2
  rd_beat1_chk: assert property (@(posedge clk_k) disable iff (!rst_n)
    rd_go |-> ##3 q_vld);

  // R2
  rd_beat3_chk: assert property (@(posedge clk_k) disable iff (!rst_n)
    rd_go |-> ##4 q_vld);

  // R8
  vld_cause_chk: assert property (@(posedge clk_k) disable iff (!rst_n)
    q_vld |-> ($past(rd_go, 3) || $past(rd_go, 4)));

  // R8
  quiet_odd_chk: assert property (@(posedge clk_k) disable iff (!rst_n)
    !q_vld |-> (q == '0));

  // R8
  quiet_even_chk: assert property (@(posedge clk_kb) disable iff (!rst_n)
    !q_vld |-> (q == '0));

  // R5
  no_stray_write_chk: assert property (@(posedge clk_k) disable iff (!rst_n)
    (wr_sel_n && !wbusy_q) |-> !pin_en);

  // R3
  commit_split_chk: assert property (@(posedge clk_k) disable iff (!rst_n)
    (kb_en && pin_en) |-> (kb_idx != pin_idx));
endmodule

bind qb4_sram qb4_sram_chk #(.DW(DW), .WAW(WAW)) u_chk (
  .clk_k(clk_k), .clk_kb(clk_kb), .rst_n(rst_n),
  .rd_sel_n(rd_sel_n), .wr_sel_n(wr_sel_n),
  .q(q), .q_vld(q_vld),
  .kb_en(kb_en), .kb_idx(kb_idx),
  .pin_en(pin_en), .pin_idx(pin_idx)
);

// File: tb/qb4_sram_test.sv
`timescale 1ns/1ps
module qb4_sram_test;
  localparam int GAW   = 4;
  localparam int LANES = 2;
  localparam int LW    = 9;
  localparam int DW    = LANES * LW;
  localparam int NG    = 1 << GAW;
  localparam int NW    = NG * 4;
  localparam int NC    = 470;
  localparam int NCT   = NC + 6;
  localparam int NH    = 2 * NCT + 8;

  logic            clk_k, clk_kb, rst_n;
  logic [GAW-1:0]  addr;
  logic            wr_sel_n, rd_sel_n;
  logic [DW-1:0]   d;
  logic [LANES-1:0] bw_n;
  logic [DW-1:0]   q;
  logic            q_oe, q_vld;

  qb4_sram #(.GROUP_AW(GAW), .LANES(LANES), .LANE_W(LW)) uut (
    .clk_k(clk_k), .clk_kb(clk_kb), .rst_n(rst_n), .addr(addr),
    .wr_sel_n(wr_sel_n), .rd_sel_n(rd_sel_n), .d(d), .bw_n(bw_n),
    .q(q), .q_oe(q_oe), .q_vld(q_vld)
  );

  // 50 MHz, the second clock exactly inverted
  initial begin
    clk_k  = 1'b0;
    clk_kb = 1'b1;
    forever #10 begin clk_k = ~clk_k; clk_kb = ~clk_kb; end
  end

  int vectors = 0;
  int fails   = 0;
  bit done    = 1'b0;

  // per-cycle stimulus
  logic [GAW-1:0]   s_addr [NC];
  logic             s_rsel [NC];
  logic             s_wsel [NC];
  logic [DW-1:0]    s_dk   [NC];
  logic [DW-1:0]    s_dkb  [NC];
  logic [LANES-1:0] s_bwk  [NC];
  logic [LANES-1:0] s_bwkb [NC];
  string            s_tag  [NC];
  // per half-cycle expectation
  logic [DW-1:0]    e_q    [NH];
  logic             e_v    [NH];
  string            e_tag  [NH];
  logic [DW-1:0]    mem_m  [NW];

  function automatic logic [31:0] mix(input int a, input int b);
    logic [31:0] x;
    x = 32'(a) * 32'h9E3779B1 + 32'(b) * 32'h85EBCA77;
    x = x ^ (x >> 15);
    x = x * 32'h2C1B3C6D;
    x = x ^ (x >> 12);
    return x;
  endfunction

  // lane l is bits l*LW+LW-1 : l*LW, written when bw_n[l] is 0 (R4)
  task automatic put(input int idx, input logic [DW-1:0] v, input logic [LANES-1:0] bn);
    for (int l = 0; l < LANES; l++)
      if (!bn[l]) mem_m[idx][l*LW +: LW] = v[l*LW +: LW];
  endtask

  task automatic build();
    int c;
    for (int i = 0; i < NC; i++) begin
      s_addr[i] = GAW'(mix(i, 7));
      s_rsel[i] = 1'b1;
      s_wsel[i] = 1'b1;
      s_dk[i]   = DW'(mix(i, 1));
      s_dkb[i]  = DW'(mix(i, 2));
      s_bwk[i]  = LANES'(mix(i, 3));
      s_bwkb[i] = LANES'(mix(i, 4));
      s_tag[i]  = "R8";
    end
    // full writes to every group; busy-cycle select and address are stray (R6, R10)
    for (int g = 0; g < NG; g++) begin
      c = 4 + 2 * g;
      s_wsel[c] = 1'b0; s_addr[c] = GAW'(g); s_bwk[c] = '0; s_bwkb[c] = '0;
      s_wsel[c+1] = 1'b0; s_addr[c+1] = ~GAW'(g); s_bwk[c+1] = '0; s_bwkb[c+1] = '0;
    end
    // back-to-back reads, select held low through busy cycles (R2 R3 R9)
    for (int g = 0; g < NG; g++) begin
      c = 36 + 2 * g;
      s_rsel[c] = 1'b0; s_addr[c] = GAW'(g); s_tag[c] = "R2 R3 R6 R9 R10";
      s_rsel[c+1] = 1'b0; s_addr[c+1] = GAW'(g ^ 5);
    end
    // masked writes covering all lane-enable pairs, then a deselected cycle (R4, R5)
    for (int g = 0; g < NG; g++) begin
      c = 68 + 3 * g;
      s_wsel[c] = 1'b0; s_addr[c] = GAW'(g);
      s_bwk[c] = LANES'(g % 4); s_bwkb[c] = LANES'((g + 1) % 4);
      s_bwk[c+1] = LANES'((g + 2) % 4); s_bwkb[c+1] = LANES'((g + 3) % 4);
      s_wsel[c+2] = 1'b1; s_bwk[c+2] = '0; s_bwkb[c+2] = '0;
    end
    for (int g = 0; g < NG; g++) begin
      c = 116 + 2 * g;
      s_rsel[c] = 1'b0; s_addr[c] = GAW'(g); s_tag[c] = "R4 R5";
    end
    // mixed traffic on four groups: same-edge and near collisions (R7)
    for (int i = 148; i < 448; i++) begin
      s_rsel[i] = mix(i, 9) [0];
      s_wsel[i] = mix(i, 9) [1];
      s_addr[i] = GAW'(mix(i, 9) >> 4) & GAW'(3);
      s_tag[i]  = "R7 R6 R9";
    end
  endtask

  // reference behaviour straight from the requirements
  task automatic predict();
    bit rb = 0, wb = 0, wt;
    int wg = 0;
    for (int h = 0; h < NH; h++) begin e_v[h] = 1'b0; e_q[h] = '0; e_tag[h] = "R8 R9"; end
    for (int i = 0; i < NW; i++) mem_m[i] = '0;
    for (int c = 0; c < NC; c++) begin
      // reads see beats sampled before this edge only
      if (!s_rsel[c] && !rb) begin
        for (int j = 0; j < 4; j++) begin
          e_v[2*c+4+j]   = 1'b1;
          e_q[2*c+4+j]   = mem_m[int'(s_addr[c])*4 + j];
          e_tag[2*c+4+j] = s_tag[c];
        end
        rb = 1;
      end else rb = 0;
      wt = !s_wsel[c] && !wb;
      if (wt) begin
        wg = int'(s_addr[c]);
        put(wg*4 + 0, s_dk[c], s_bwk[c]);
        put(wg*4 + 1, s_dkb[c], s_bwkb[c]);
      end else if (wb) begin
        put(wg*4 + 2, s_dk[c], s_bwk[c]);
        put(wg*4 + 3, s_dkb[c], s_bwkb[c]);
      end
      wb = wt;
    end
  endtask

  task automatic check_half(input int h);
    vectors++;
    if (e_v[h]) begin
      if (q_vld !== 1'b1 || q_oe !== 1'b1 || q !== e_q[h]) begin
        fails++;
        $display("FAIL %s half %0d: q=%h vld=%b oe=%b, expected q=%h vld=1 oe=1",
                 e_tag[h], h, q, q_vld, q_oe, e_q[h]);
      end
    end else if (q_vld !== 1'b0 || q_oe !== 1'b0 || q !== '0) begin
      fails++;
      $display("FAIL %s half %0d: q=%h vld=%b oe=%b, expected q=0 vld=0 oe=0",
               e_tag[h], h, q, q_vld, q_oe);
    end
  endtask

  initial begin
    #4_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; rd_sel_n = 1'b1; wr_sel_n = 1'b1;
    addr = '0; d = '0; bw_n = '1;
    build();
    predict();
    // R1: outputs quiet during reset
    #5;
    vectors++;
    if (q_vld !== 1'b0 || q_oe !== 1'b0 || q !== '0) begin
      fails++;
      $display("FAIL R1 reset: q=%h vld=%b oe=%b, expected q=0 vld=0 oe=0", q, q_vld, q_oe);
    end
    #40 rst_n = 1'b1;
    for (int c = 0; c < NCT; c++) begin
      @(posedge clk_kb); #5;
      if (c > 0) check_half(2*c - 1);
      if (c < NC) begin
        addr = s_addr[c]; rd_sel_n = s_rsel[c]; wr_sel_n = s_wsel[c];
        d = s_dk[c]; bw_n = s_bwk[c];
      end else begin
        rd_sel_n = 1'b1; wr_sel_n = 1'b1;
      end
      @(posedge clk_k); #5;
      check_half(2*c);
      if (c < NC) begin d = s_dkb[c]; bw_n = s_bwkb[c]; end
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule